// File: doc/BRIEF.md
# Completion Acknowledge Bitmap Bank

This block gathers receive-done notifications for one physical function. Each function that can receive a message from that physical function owns a single bit in a bank of 32-bit words. When that destination signals that it has consumed the message, a one-cycle event strobe arrives carrying its function ID, and the block sets the matching bit. Software can poll one summary flag instead of scanning every word. When the flag is high, software reads the words. One read can return many completions at once.

Software acknowledges completions by writing back the value it read. Each bit that is one in the written value is cleared, and each bit that is zero is left alone. So completions that arrive between the read and the write-back are kept. If an event and a clear hit the same bit in the same cycle, the set takes priority, so no acknowledge is lost. The read port has one cycle of latency. The summary flag is a registered OR of the whole bank.

Top module: `ackbm_bank`

## Requirements
- R1: After a synchronous active-high reset, every bank word is zero, `ack_pending` is 0 and `reg_rd_data` is 0.
- R2: An event with function ID N sets bit N mod 32 of word N div 32. The word index is the ID shifted right by 5, and the bit position is the low 5 bits of the ID. No other bit changes.
- R3: Events accumulate. Several completions that land in one word are all returned by a single read of that word.
- R4: A write to word W clears exactly the bits of W that are 1 in `reg_wr_data`. Bits written as 0 keep their value, and other words are not affected.
- R5: When an event sets a bit in the same cycle that a write clears that same bit, the bit ends up set.
- R6: `ack_pending` is registered. It rises one cycle after the first bit of the bank is set, and it falls one cycle after the last set bit is cleared.
- R7: `reg_rd_data` updates on the clock edge where `reg_rd_en` is sampled high. It shows the word as it was before any event or write taken on that same edge. It holds its value while `reg_rd_en` is low.
- R8: Function IDs 0 and NUM_FUNCS-1 map to bit 0 of word 0 and to bit 31 of the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_ev_valid | input | 1 | One-cycle receive-done event strobe |
| ack_ev_fid | input | FID_W | Function ID of the destination that finished receiving |
| reg_wr_en | input | 1 | Write-one-to-clear strobe |
| reg_wr_addr | input | AW | Word index for the write |
| reg_wr_data | input | 32 | Mask of bits to clear |
| reg_rd_en | input | 1 | Read strobe |
| reg_rd_addr | input | AW | Word index for the read |
| reg_rd_data | output | 32 | Registered read data |
| ack_pending | output | 1 | Registered OR of every bank bit |

## Verification
The bench drives an event and a clear to one bit in the same cycle. A design that let the clear win would drop the bit, and the read-back would show it missing. It writes masks that include bits which are not set, and it writes all-zero masks. A design that stored the written value, or that inverted the mask, would disturb bits that should stay unchanged. It times `ack_pending` to the exact cycle on both its rising and falling edges, which exposes a combinational flag or one delayed by an extra stage. It also reads a word on the same edge that an event updates it, so a read path that bypassed the new value would return the wrong word. IDs 0 and the last ID are sent to catch off-by-one errors in the index and bit decode.

// File: rtl/ackbm_pkg.sv
package ackbm_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = 5;
  typedef logic [WORD_W-1:0] ack_word_t;
endpackage

// File: rtl/ackbm_decode.sv
// Turns one event strobe into a per-word set mask.
module ackbm_decode
  import ackbm_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int FID_W     = 8
) (
  input  logic                       ev_valid,
  input  logic [FID_W-1:0]           ev_fid,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] set_mask
);
  logic [FID_W-1:0] word_idx;
  logic [BIT_W-1:0] bit_pos;
  ack_word_t        onehot;

  assign word_idx = ev_fid >> BIT_W;
  assign bit_pos  = ev_fid[BIT_W-1:0];
  assign onehot   = ack_word_t'(1) << bit_pos;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_mask
    assign set_mask[w] = (ev_valid && (word_idx == FID_W'(w))) ? onehot : '0;
  end
endmodule

// File: rtl/ackbm_word.sv
// One acknowledge word: write-one-to-clear, set has priority.
module ackbm_word
  import ackbm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ack_word_t set_mask,
  input  logic      clr_en,
  input  ack_word_t clr_mask,
  output ack_word_t q
);
  ack_word_t clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q & ~clr_eff) | set_mask;
  end
endmodule

// File: rtl/ackbm_rdport.sv
// Registered read mux over the bank.
module ackbm_rdport
  import ackbm_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int AW        = 3
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             rd_en,
  input  logic [AW-1:0]                    rd_addr,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] bank,
  output ack_word_t                        rd_data
);
  ack_word_t sel;

  always_comb begin
    sel = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (rd_addr == AW'(w)) sel = bank[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/ackbm_summary.sv
// Registered OR-reduction of the whole bank.
module ackbm_summary
  import ackbm_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_WORDS-1:0][WORD_W-1:0] bank,
  output logic                             any_q
);
  logic [NUM_WORDS-1:0] word_any;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_or
    assign word_any[w] = |bank[w];
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |word_any;
  end
endmodule

// File: rtl/ackbm_bank.sv
module ackbm_bank
  import ackbm_pkg::*;
#(
  parameter int NUM_FUNCS = 256,
  localparam int NUM_WORDS = (NUM_FUNCS + WORD_W - 1) / WORD_W,
  localparam int FID_W     = (NUM_FUNCS > 32) ? $clog2(NUM_FUNCS) : BIT_W,
  localparam int AW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ack_ev_valid,
  input  logic [FID_W-1:0] ack_ev_fid,
  input  logic             reg_wr_en,
  input  logic [AW-1:0]    reg_wr_addr,
  input  logic [31:0]      reg_wr_data,
  input  logic             reg_rd_en,
  input  logic [AW-1:0]    reg_rd_addr,
  output logic [31:0]      reg_rd_data,
  output logic             ack_pending
);
  logic [NUM_WORDS-1:0][WORD_W-1:0] set_mask;
  logic [NUM_WORDS-1:0][WORD_W-1:0] bank_q;

  ackbm_decode #(.NUM_WORDS(NUM_WORDS), .FID_W(FID_W)) dec_i (
    .ev_valid (ack_ev_valid),
    .ev_fid   (ack_ev_fid),
    .set_mask (set_mask)
  );

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic clr_hit;
    assign clr_hit = reg_wr_en && (reg_wr_addr == AW'(w));
    ackbm_word word_i (
      .clk      (clk),
      .rst      (rst),
      .set_mask (set_mask[w]),
      .clr_en   (clr_hit),
      .clr_mask (reg_wr_data),
      .q        (bank_q[w])
    );
  end

  ackbm_rdport #(.NUM_WORDS(NUM_WORDS), .AW(AW)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (reg_rd_en),
    .rd_addr (reg_rd_addr),
    .bank    (bank_q),
    .rd_data (reg_rd_data)
  );

  ackbm_summary #(.NUM_WORDS(NUM_WORDS)) sum_i (
    .clk   (clk),
    .rst   (rst),
    .bank  (bank_q),
    .any_q (ack_pending)
  );
endmodule

// File: rtl/ackbm_bank_chk.sv
module ackbm_bank_chk #(
  parameter int NUM_WORDS = 8,
  parameter int FID_W     = 8,
  parameter int AW        = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      ack_ev_valid,
  input logic [FID_W-1:0]          ack_ev_fid,
  input logic                      reg_wr_en,
  input logic [AW-1:0]             reg_wr_addr,
  input logic [31:0]               reg_wr_data,
  input logic                      reg_rd_en,
  input logic [31:0]               reg_rd_data,
  input logic                      ack_pending,
  input logic [NUM_WORDS*32-1:0]   bank_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!ack_pending && reg_rd_data == 32'd0 && bank_flat == '0));

  // R2
  event_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ack_ev_valid |=> bank_flat[$past(ack_ev_fid)]);

  // R4
  clear_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !ack_ev_valid && (int'(reg_wr_addr) < NUM_WORDS)) |=>
      ((bank_flat[int'($past(reg_wr_addr))*32 +: 32] & $past(reg_wr_data)) == 32'd0));

  // R6
  pending_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ack_ev_valid |-> ##2 ack_pending);

  // R6
  pending_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_flat == '0) |=> !ack_pending);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_rd_en) && !$past(rst)) |-> $stable(reg_rd_data));
endmodule

bind ackbm_bank ackbm_bank_chk #(.NUM_WORDS(NUM_WORDS), .FID_W(FID_W), .AW(AW)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .ack_ev_valid (ack_ev_valid),
  .ack_ev_fid   (ack_ev_fid),
  .reg_wr_en    (reg_wr_en),
  .reg_wr_addr  (reg_wr_addr),
  .reg_wr_data  (reg_wr_data),
  .reg_rd_en    (reg_rd_en),
  .reg_rd_data  (reg_rd_data),
  .ack_pending  (ack_pending),
  .bank_flat    (bank_q)
);

// File: tb/ackbm_bank_tb_top.sv
module ackbm_bank_tb_top;
  localparam int NF = 256;
  localparam int FW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ev_valid = 1'b0;
  logic [FW-1:0] ev_fid = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic          pending;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ackbm_bank #(.NUM_FUNCS(NF)) dut_i (
    .clk(clk), .rst(rst),
    .ack_ev_valid(ev_valid), .ack_ev_fid(ev_fid),
    .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
    .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
    .ack_pending(pending)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_ev(input logic [FW-1:0] fid);
    @(negedge clk); ev_valid = 1'b1; ev_fid = fid;
    @(negedge clk); ev_valid = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rd_data", rd_data, 32'd0);
    check("R1 pending", {31'd0, pending}, 32'd0);
    for (int w = 0; w < 8; w++) begin
      do_read(AW'(w), d);
      check("R1 word", d, 32'd0);
    end
  endtask

  task automatic t_single();
    logic [31:0] d;
    send_ev(8'd37);
    do_read(3'd1, d); check("R2 word1", d, 32'h0000_0020);
    do_read(3'd0, d); check("R2 word0", d, 32'd0);
    do_read(3'd2, d); check("R2 word2", d, 32'd0);
    do_write(3'd1, 32'h0000_0020);
    do_read(3'd1, d); check("R4 word1 cleared", d, 32'd0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    send_ev(8'd64); send_ev(8'd95); send_ev(8'd70); send_ev(8'd200);
    do_read(3'd2, d); check("R3 word2 multi", d, 32'h8000_0041);
    do_read(3'd6, d); check("R3 word6", d, 32'h0000_0100);
    // R4: clear bit31 plus an unset bit3; zero mask afterwards
    do_write(3'd2, 32'h8000_0008);
    do_read(3'd2, d); check("R4 partial clear", d, 32'h0000_0041);
    do_write(3'd2, 32'h0);
    do_read(3'd2, d); check("R4 zero mask", d, 32'h0000_0041);
    do_read(3'd6, d); check("R4 other word kept", d, 32'h0000_0100);
    do_write(3'd2, 32'h0000_0041);
    do_write(3'd6, 32'h0000_0100);
    do_read(3'd2, d); check("R4 word2 empty", d, 32'd0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    send_ev(8'd6);
    @(negedge clk);
    ev_valid = 1'b1; ev_fid = 8'd5;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'h0000_0060;
    @(negedge clk); ev_valid = 1'b0; wr_en = 1'b0;
    do_read(3'd0, d); check("R5 set wins", d, 32'h0000_0020);
    do_write(3'd0, 32'h0000_0020);
  endtask

  task automatic t_pending();
    // bank empty; wait for summary to settle
    @(negedge clk);
    check("R6 idle low", {31'd0, pending}, 32'd0);
    send_ev(8'd130);
    check("R6 not yet", {31'd0, pending}, 32'd0);
    @(negedge clk);
    check("R6 rise", {31'd0, pending}, 32'd1);
    do_write(3'd4, 32'h0000_0004);
    check("R6 still high", {31'd0, pending}, 32'd1);
    @(negedge clk);
    check("R6 fall", {31'd0, pending}, 32'd0);
  endtask

  task automatic t_read_same_edge();
    logic [31:0] d;
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 3'd3; ev_valid = 1'b1; ev_fid = 8'd97;
    @(negedge clk);
    rd_en = 1'b0; ev_valid = 1'b0;
    check("R7 old value", rd_data, 32'd0);
    @(negedge clk); @(negedge clk);
    check("R7 hold", rd_data, 32'd0);
    do_read(3'd3, d); check("R7 new value", d, 32'h0000_0002);
    do_write(3'd3, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges();
    logic [31:0] d;
    send_ev(8'd0); send_ev(8'd255);
    do_read(3'd0, d); check("R8 first id", d, 32'h0000_0001);
    do_read(3'd7, d); check("R8 last id", d, 32'h8000_0000);
    do_write(3'd0, 32'h1); do_write(3'd7, 32'h8000_0000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_collide();
    t_pending();
    t_read_same_edge();
    t_edges();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule